// File: doc/BRIEF.md
# Left Shifter with Flag Generation

This block is the left-shift path of a two's-complement ALU. It takes a data operand, an unsigned shift count and the five incoming condition flags (carry, overflow, sign, zero, parity). It returns the shifted value and the updated flags. A single left shift serves both signed and unsigned code. Code working on unsigned values simply ignores the overflow flag.

The shift itself is a logarithmic barrel shifter, so every count takes the same time. Overflow is the exclusive-OR of the operand's top bit and the result's top bit, and it is produced for every nonzero count. A multi-bit shift can change the sign and then change it back. That case gives overflow 0, so overflow 0 does not prove that no overflow occurred.

Carry is the last bit that leaves the top of the word. A count of zero passes the operand through and keeps every flag as it came in. Result and flags are registered once, so they appear one clock after the inputs.

Top module: `lshf_unit`

## Requirements
- R1: For a count c with 0 < c < DATA_W, result_o equals operand_i shifted left by c. The high bits are dropped and zeros enter at bit 0.
- R2: For a count greater than or equal to DATA_W, result_o is all zeros and carry_o is 0.
- R3: For any nonzero count, ovf_o equals operand_i[DATA_W-1] XOR result_o[DATA_W-1]. This holds for multi-bit counts too: a sign change that a later shift step reverses yields 0.
- R4: For 0 < c < DATA_W, carry_o equals operand_i[DATA_W-c], the last bit shifted out of the top.
- R5: For any nonzero count, sign_o equals result_o[DATA_W-1], and zero_o is 1 exactly when result_o is all zeros.
- R6: For any nonzero count, parity_o is 1 when result_o[7:0] holds an even number of one bits, and 0 otherwise.
- R7: For a count of zero, result_o equals operand_i, and each flag output equals the matching flag input.
- R8: Outputs change only on the rising clock edge after the inputs are applied. While rst_n is low, result_o and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| operand_i | input | DATA_W | Two's-complement operand |
| count_i | input | CNT_W | Unsigned shift count, CNT_W = log2(DATA_W)+1 |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| sign_i | input | 1 | Incoming sign flag |
| zero_i | input | 1 | Incoming zero flag |
| parity_i | input | 1 | Incoming parity flag |
| result_o | output | DATA_W | Registered shifted value |
| carry_o | output | 1 | Registered carry flag |
| ovf_o | output | 1 | Registered overflow flag |
| sign_o | output | 1 | Registered sign flag |
| zero_o | output | 1 | Registered zero flag |
| parity_o | output | 1 | Registered parity flag |

## Verification
The delicate overlap is the full-width shift of a negative operand. In one cycle, the result-clearing rule (zero result, carry forced to 0) meets the overflow rule, which must still report the lost sign bit, so zero and overflow are both 1. The bench drives a negative operand with counts of exactly DATA_W and of the largest encodable count. It compares every output against a bit-serial model. A second overlap is a multi-bit shift whose sign flips and flips back, with carry taken from a bit set in the operand. The bench judges that overflow stays 0 while carry is 1.

// File: rtl/lshf_pkg.sv
package lshf_pkg;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic sign;
        logic zero;
        logic parity;
    } lshf_flags_t;

endpackage

// File: rtl/lshf_barrel.sv
module lshf_barrel #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              active_o
);
    localparam int                STAGES = CNT_W - 1;
    localparam logic [CNT_W-1:0] LIMIT  = CNT_W'(DATA_W);

    // Bit DATA_W of each stage holds the latest bit pushed out of the word.
    logic [DATA_W:0] stage [0:STAGES];
    logic            over;

    assign stage[0] = {1'b0, operand_i};

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stage[k+1] = count_i[k] ? (stage[k] << SH) : stage[k];
        end
    endgenerate

    assign over     = (count_i >= LIMIT);
    assign active_o = (count_i != '0);
    assign result_o = over ? '0 : stage[STAGES][DATA_W-1:0];
    assign carry_o  = (over || !active_o) ? 1'b0 : stage[STAGES][DATA_W];

endmodule

// File: rtl/lshf_flags.sv
module lshf_flags
    import lshf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              active_i,
    input  logic              op_msb_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              carry_i,
    input  lshf_flags_t       flags_i,
    output lshf_flags_t       flags_o
);
    localparam int PAR_W = (DATA_W < 8) ? DATA_W : 8;

    always_comb begin
        if (!active_i) begin
            flags_o = flags_i;
        end else begin
            flags_o.carry  = carry_i;
            flags_o.ovf    = op_msb_i ^ result_i[DATA_W-1];
            flags_o.sign   = result_i[DATA_W-1];
            flags_o.zero   = (result_i == '0);
            flags_o.parity = ~(^result_i[PAR_W-1:0]);
        end
    end

endmodule

// File: rtl/lshf_unit.sv
module lshf_unit
    import lshf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    input  logic              sign_i,
    input  logic              zero_i,
    input  logic              parity_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              sign_o,
    output logic              zero_o,
    output logic              parity_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        lshf_flags_t       flags;
    } lshf_state_t;

    lshf_state_t st_d, st_q;

    logic [DATA_W-1:0] shifted;
    logic              shift_carry;
    logic              shift_active;
    lshf_flags_t       flags_in;
    lshf_flags_t       flags_new;

    assign flags_in = '{carry: carry_i, ovf: ovf_i, sign: sign_i,
                        zero: zero_i, parity: parity_i};

    lshf_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_barrel (
        .operand_i (operand_i),
        .count_i   (count_i),
        .result_o  (shifted),
        .carry_o   (shift_carry),
        .active_o  (shift_active)
    );

    lshf_flags #(.DATA_W(DATA_W)) u_flags (
        .active_i (shift_active),
        .op_msb_i (operand_i[DATA_W-1]),
        .result_i (shifted),
        .carry_i  (shift_carry),
        .flags_i  (flags_in),
        .flags_o  (flags_new)
    );

    always_comb begin
        st_d.result = shifted;
        st_d.flags  = flags_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign carry_o  = st_q.flags.carry;
    assign ovf_o    = st_q.flags.ovf;
    assign sign_o   = st_q.flags.sign;
    assign zero_o   = st_q.flags.zero;
    assign parity_o = st_q.flags.parity;

    // Marks that at least one clock has passed since reset released.
    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    p_hold_on_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(count_i) == '0) |->
        (result_o == $past(operand_i) && carry_o == $past(carry_i) &&
         ovf_o == $past(ovf_i) && sign_o == $past(sign_i) &&
         zero_o == $past(zero_i) && parity_o == $past(parity_i)));

    p_clear_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(count_i) >= LIMIT) |->
        (result_o == '0 && !carry_o));

    p_ovf_sign_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(count_i) != '0) |->
        (ovf_o == ($past(operand_i[DATA_W-1]) ^ result_o[DATA_W-1])));

    p_sign_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(count_i) != '0) |->
        (sign_o == result_o[DATA_W-1] && zero_o == (result_o == '0)));

    p_reset_clear_r8: assert property (@(posedge clk)
        $past(!rst_n) |-> (result_o == '0 && !carry_o && !ovf_o &&
                           !sign_o && !zero_o && !parity_o));

endmodule

// File: tb/sim_lshf_unit.sv
module sim_lshf_unit;
    localparam int N  = 16;
    localparam int CW = $clog2(N) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  operand_i = '0;
    logic [CW-1:0] count_i = '0;
    logic          carry_i = 0, ovf_i = 0, sign_i = 0, zero_i = 0, parity_i = 0;
    logic [N-1:0]  result_o;
    logic          carry_o, ovf_o, sign_o, zero_o, parity_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    lshf_unit #(.DATA_W(N), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .count_i(count_i),
        .carry_i(carry_i), .ovf_i(ovf_i), .sign_i(sign_i), .zero_i(zero_i),
        .parity_i(parity_i), .result_o(result_o), .carry_o(carry_o),
        .ovf_o(ovf_o), .sign_o(sign_o), .zero_o(zero_o), .parity_o(parity_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bit-serial reference: one position per step, tracking the bit that leaves.
    task automatic model(input logic [N-1:0] op, input int cnt, input logic [4:0] fin,
                         output logic [N-1:0] r, output logic [4:0] f);
        logic [N-1:0] v = op;
        logic         c = 1'b0;
        int           ones = 0;
        if (cnt == 0) begin
            r = op; f = fin;
            return;
        end
        for (int i = 0; i < cnt && i < N; i++) begin
            c = v[N-1];
            v = {v[N-2:0], 1'b0};
        end
        if (cnt >= N) begin v = '0; c = 1'b0; end
        for (int i = 0; i < 8; i++) ones += v[i];
        r = v;
        f = {c, op[N-1] != v[N-1], v[N-1], v == '0, (ones % 2) == 0};
    endtask

    task automatic drive(input logic [N-1:0] op, input int cnt, input logic [4:0] fin);
        @(negedge clk);
        operand_i = op;
        count_i   = CW'(cnt);
        {carry_i, ovf_i, sign_i, zero_i, parity_i} = fin;
    endtask

    task automatic run(string req, input logic [N-1:0] op, input int cnt, input logic [4:0] fin);
        logic [N-1:0] er;
        logic [4:0]   ef;
        model(op, cnt, fin, er, ef);
        drive(op, cnt, fin);
        @(posedge clk); #1;
        chk(req, "result", 32'(result_o), 32'(er));
        chk(req, "carry",  32'(carry_o),  32'(ef[4]));
        chk(req, "ovf",    32'(ovf_o),    32'(ef[3]));
        chk(req, "sign",   32'(sign_o),   32'(ef[2]));
        chk(req, "zero",   32'(zero_o),   32'(ef[1]));
        chk(req, "parity", 32'(parity_o), 32'(ef[0]));
    endtask

    task automatic t_reset;
        drive(16'hFFFF, 3, 5'b11111);
        @(posedge clk); #1;
        chk("R8", "reset outputs", 32'({result_o, carry_o, ovf_o, sign_o, zero_o, parity_o}), 32'd0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_sign_flip;   // R3 and R1: the 4-bit example scaled to 16 bits
        run("R3", 16'h5000, 1, 5'b00000);
        chk("R3", "ovf set on 0101<<1", 32'(ovf_o), 32'd1);
        chk("R1", "0x5000<<1", 32'(result_o), 32'h0000A000);
    endtask

    task automatic t_undone_flip; // R3 and R4: sign flips then returns
        run("R3", 16'h5000, 2, 5'b00000);
        chk("R3", "ovf 0 after undone flip", 32'(ovf_o), 32'd0);
        chk("R4", "carry is bit 14", 32'(carry_o), 32'd1);
    endtask

    task automatic t_zero_count;  // R7
        run("R7", 16'h8C31, 0, 5'b10101);
        run("R7", 16'h0000, 0, 5'b01010);
    endtask

    task automatic t_wide;        // R2 with R3 in the same cycle
        run("R2", 16'h8001, 16, 5'b00000);
        chk("R2", "ovf and zero together", 32'({ovf_o, zero_o}), 32'd3);
        run("R2", 16'hFFFF, 31, 5'b10000);
        run("R2", 16'h1234, 17, 5'b11111);
    endtask

    task automatic t_sweep;       // R1 R4 R5 over every in-range count
        for (int c = 1; c < N; c++) run("R4", 16'hB6D3, c, 5'b01011);
        for (int c = 1; c < N; c++) run("R5", 16'h0001, c, 5'b00000);
    endtask

    task automatic t_parity;      // R6
        run("R6", 16'h0033, 1, 5'b00000);
        run("R6", 16'h0007, 1, 5'b00001);
        run("R6", 16'hFF80, 1, 5'b00001);
    endtask

    task automatic t_latency;     // R8: no change before the clock edge
        logic [N-1:0] prev;
        run("R8", 16'h0101, 4, 5'b00000);
        prev = result_o;
        drive(16'hAAAA, 1, 5'b00000);
        #2;
        chk("R8", "held before edge", 32'(result_o), 32'(prev));
        @(posedge clk); #1;
        chk("R8", "updated after edge", 32'(result_o), 32'h00005554);
    endtask

    initial begin
        t_reset;
        t_sign_flip;
        t_undone_flip;
        t_zero_count;
        t_wide;
        t_sweep;
        t_parity;
        t_latency;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule